// File: doc/BRIEF.md
# Memory Select and Strobe Router

This block sits on a microcontroller's external memory bus. In each cycle it takes the read, write and program-fetch strobes, along with the region-match flags from separate address decoders. It then asserts the select of exactly one target, or of none. The four targets are an on-chip SRAM, a register block, a secondary flash and a main flash. A fifth target, a peripheral I/O window, takes part only while it is enabled.

When region matches overlap, a fixed priority decides which target owns the cycle. A small routing register then decides whether the owner may answer this kind of cycle, so that each memory can be placed in program space, data space or both.

The routing register loads a parameterised default on every reset. The CPU can rewrite it with a data write to its address in the register block. Data reads of that address return its contents. Every other cycle drives a fixed idle value on the read bus.

Top module: `memRouter`

## Requirements
- R1: While `rstN` is low at a clock edge, the routing register loads `CFG_DEFAULT` with bits 6:5 cleared (default 8'h0C).
- R2: A data write that selects the register block at address `CFG_ADDR` stores `busWdata` with bits 6:5 forced to zero at the next clock edge. The value stays until the next write or reset.
- R3: The claim priority is SRAM, then register block, then peripheral I/O, then secondary flash, then main flash. The highest matching region owns the cycle. If it is not enabled for the cycle type, no select is asserted, and a lower region does not take the cycle.
- R4: SRAM is selected on every data read or write it owns. On a fetch it is selected only when register bit 0 is 1.
- R5: Main flash answers fetches when bit 1 is set and data cycles when bit 3 is set. Secondary flash answers fetches when bit 2 is set and data cycles when bit 4 is set. With 8'h0C, secondary flash is in program space and main flash is in data space.
- R6: The register block answers data cycles only and is never selected by a fetch.
- R7: The peripheral I/O window claims cycles only while bit 7 is 1, and it answers data cycles only. Bit 7 changes no SRAM or flash routing.
- R8: At most one select is high in any cycle. With no strobe active, no select is high.
- R9: `rdData` carries the register value on a data read of `CFG_ADDR` that selects the register block. In every other cycle it carries `IDLE_DATA` (8'hFF).
- R10: An active `busFetch` makes the cycle a fetch even when `busRd` or `busWr` is also high, so such a cycle never writes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busFetch | input | 1 | Program-fetch strobe |
| busRd | input | 1 | Data read strobe |
| busWr | input | 1 | Data write strobe |
| busAddr | input | ADDR_W | Bus address |
| busWdata | input | 8 | Write data |
| hitSram | input | 1 | SRAM region match |
| hitRegs | input | 1 | Register block region match |
| hitPio | input | 1 | Peripheral I/O region match |
| hitSec | input | 1 | Secondary flash region match |
| hitMain | input | 1 | Main flash region match |
| selSram | output | 1 | SRAM select |
| selRegs | output | 1 | Register block select |
| selPio | output | 1 | Peripheral I/O select |
| selSec | output | 1 | Secondary flash select |
| selMain | output | 1 | Main flash select |
| rdData | output | 8 | Read data (register value or idle value) |
| cfgValue | output | 8 | Current routing register contents |
| pioEn | output | 1 | Peripheral I/O enable (register bit 7) |

## Verification
A register rewrite and a routing decision can fall in the same cycle. A write to `CFG_ADDR` must be routed under the old register value, and the new value must steer only the cycles that follow. The random stimulus often aims writes at `CFG_ADDR` while several region flags are set at once. The bench model updates its copy of the register only at the clock edge, so every select in the write cycle is judged against the old value. A write merged with a fetch strobe is provoked on purpose, and the check is that the register keeps its value.

// File: rtl/memRouterPkg.sv
package memRouterPkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_KEEP = 8'h9F;
  localparam int B_SRAM_CODE = 0;
  localparam int B_MAIN_CODE = 1;
  localparam int B_SEC_CODE  = 2;
  localparam int B_MAIN_DATA = 3;
  localparam int B_SEC_DATA  = 4;
  localparam int B_PIO_EN    = 7;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_SRAM, WIN_REGS, WIN_PIO, WIN_SEC, WIN_MAIN
  } winner_e;

  typedef struct packed {
    logic    fetch;
    logic    data;
    logic    write;
    logic    read;
    winner_e winner;
  } busStrobes_t;
endpackage

// File: rtl/memRouterCtrl.sv
module memRouterCtrl
  import memRouterPkg::*;
(
  input  logic        busFetch,
  input  logic        busRd,
  input  logic        busWr,
  input  logic        hitSram,
  input  logic        hitRegs,
  input  logic        hitPio,
  input  logic        hitSec,
  input  logic        hitMain,
  input  logic        pioEn,
  output busStrobes_t strobes
);
  localparam int N_REG = 5;

  logic [N_REG-1:0] hitVec;
  winner_e          winTab [N_REG];
  logic             active;

  // index 0 is the highest priority
  assign hitVec = {hitMain, hitSec, hitPio & pioEn, hitRegs, hitSram};
  assign winTab[0] = WIN_SRAM;
  assign winTab[1] = WIN_REGS;
  assign winTab[2] = WIN_PIO;
  assign winTab[3] = WIN_SEC;
  assign winTab[4] = WIN_MAIN;

  assign active = busFetch | busRd | busWr;

  always_comb begin
    strobes.fetch  = busFetch;
    strobes.data   = ~busFetch & (busRd | busWr);
    strobes.write  = ~busFetch & busWr;
    strobes.read   = ~busFetch & busRd & ~busWr;
    strobes.winner = WIN_NONE;
    if (active) begin
      for (int i = N_REG - 1; i >= 0; i--) begin
        if (hitVec[i]) strobes.winner = winTab[i];
      end
    end
  end
endmodule

// File: rtl/memRouterDp.sv
module memRouterDp
  import memRouterPkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 16'h00B0,
  parameter logic [CFG_W-1:0]  CFG_DEFAULT = 8'h0C,
  parameter logic [CFG_W-1:0]  IDLE_DATA   = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CFG_W-1:0]  busWdata,
  output logic              selSram,
  output logic              selRegs,
  output logic              selPio,
  output logic              selSec,
  output logic              selMain,
  output logic [CFG_W-1:0]  rdData,
  output logic [CFG_W-1:0]  cfgValue,
  output logic              pioEn
);
  logic [CFG_W-1:0] cfgQ;
  logic             allow;
  logic             addrHit;
  logic             cfgWe;

  always_ff @(posedge clk) begin
    if (!rstN)      cfgQ <= CFG_DEFAULT & CFG_KEEP;
    else if (cfgWe) cfgQ <= busWdata & CFG_KEEP;
  end

  always_comb begin
    case (strobes.winner)
      WIN_SRAM: allow = strobes.data | (strobes.fetch & cfgQ[B_SRAM_CODE]);
      WIN_REGS: allow = strobes.data;
      WIN_PIO:  allow = strobes.data;
      WIN_SEC:  allow = (strobes.fetch & cfgQ[B_SEC_CODE]) |
                        (strobes.data & cfgQ[B_SEC_DATA]);
      WIN_MAIN: allow = (strobes.fetch & cfgQ[B_MAIN_CODE]) |
                        (strobes.data & cfgQ[B_MAIN_DATA]);
      default:  allow = 1'b0;
    endcase
  end

  assign selSram = allow & (strobes.winner == WIN_SRAM);
  assign selRegs = allow & (strobes.winner == WIN_REGS);
  assign selPio  = allow & (strobes.winner == WIN_PIO);
  assign selSec  = allow & (strobes.winner == WIN_SEC);
  assign selMain = allow & (strobes.winner == WIN_MAIN);

  assign addrHit  = (busAddr == CFG_ADDR);
  assign cfgWe    = selRegs & strobes.write & addrHit;
  assign rdData   = (selRegs & strobes.read & addrHit) ? cfgQ : IDLE_DATA;
  assign cfgValue = cfgQ;
  assign pioEn    = cfgQ[B_PIO_EN];
endmodule

// File: rtl/memRouter.sv
module memRouter
  import memRouterPkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 16'h00B0,
  parameter logic [7:0]        CFG_DEFAULT = 8'h0C,
  parameter logic [7:0]        IDLE_DATA   = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busFetch,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              hitSram,
  input  logic              hitRegs,
  input  logic              hitPio,
  input  logic              hitSec,
  input  logic              hitMain,
  output logic              selSram,
  output logic              selRegs,
  output logic              selPio,
  output logic              selSec,
  output logic              selMain,
  output logic [7:0]        rdData,
  output logic [7:0]        cfgValue,
  output logic              pioEn
);
  busStrobes_t strobes;

  memRouterCtrl u_ctrl (
    .busFetch(busFetch), .busRd(busRd), .busWr(busWr),
    .hitSram(hitSram), .hitRegs(hitRegs), .hitPio(hitPio),
    .hitSec(hitSec), .hitMain(hitMain), .pioEn(pioEn),
    .strobes(strobes)
  );

  memRouterDp #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR),
    .CFG_DEFAULT(CFG_DEFAULT), .IDLE_DATA(IDLE_DATA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busAddr(busAddr), .busWdata(busWdata),
    .selSram(selSram), .selRegs(selRegs), .selPio(selPio),
    .selSec(selSec), .selMain(selMain),
    .rdData(rdData), .cfgValue(cfgValue), .pioEn(pioEn)
  );
endmodule

// File: rtl/memRouterChk.sv
module memRouterChk #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 16'h00B0,
  parameter logic [7:0]        CFG_DEFAULT = 8'h0C,
  parameter logic [7:0]        IDLE_DATA   = 8'hFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              busFetch,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              hitSram,
  input logic              selSram,
  input logic              selRegs,
  input logic              selPio,
  input logic              selSec,
  input logic              selMain,
  input logic [7:0]        rdData,
  input logic [7:0]        cfgValue,
  input logic              pioEn
);
  p_reset_load_r1: assert property (@(posedge clk)
    !rstN |=> cfgValue == (CFG_DEFAULT & 8'h9F));

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busFetch && busWr && selRegs && busAddr == CFG_ADDR)
      |=> cfgValue == ($past(busWdata) & 8'h9F));

  p_pad_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgValue[6:5] == 2'b00);

  p_sram_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busFetch && (busRd || busWr) && hitSram) |-> selSram);

  p_regs_no_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    busFetch |-> !selRegs && !selPio);

  p_pio_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    selPio |-> pioEn);

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selSram, selRegs, selPio, selSec, selMain}));

  p_idle_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busFetch || busRd || busWr) |-> !(selSram || selRegs || selPio || selSec || selMain));

  p_idle_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    !selRegs |-> rdData == IDLE_DATA);

  p_fetch_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    busFetch |=> $stable(cfgValue));
endmodule

bind memRouter memRouterChk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR),
  .CFG_DEFAULT(CFG_DEFAULT), .IDLE_DATA(IDLE_DATA)
) u_chk (
  .clk(clk), .rstN(rstN), .busFetch(busFetch), .busRd(busRd), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .hitSram(hitSram),
  .selSram(selSram), .selRegs(selRegs), .selPio(selPio),
  .selSec(selSec), .selMain(selMain),
  .rdData(rdData), .cfgValue(cfgValue), .pioEn(pioEn)
);

// File: tb/memRouter_tb.sv
`timescale 1ns/1ps
module memRouter_tb;
  localparam logic [15:0] CADDR = 16'h00B0;
  localparam logic [7:0]  CDEF  = 8'h0C;
  localparam logic [7:0]  IDLE  = 8'hFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busFetch = 0, busRd = 0, busWr = 0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic hitSram = 0, hitRegs = 0, hitPio = 0, hitSec = 0, hitMain = 0;
  logic selSram, selRegs, selPio, selSec, selMain, pioEn;
  logic [7:0] rdData, cfgValue;

  int testCnt = 0;
  int failCnt = 0;
  logic [7:0] model = CDEF;

  always #2.5 clk = ~clk;

  memRouter u_dut (
    .clk(clk), .rstN(rstN), .busFetch(busFetch), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata),
    .hitSram(hitSram), .hitRegs(hitRegs), .hitPio(hitPio),
    .hitSec(hitSec), .hitMain(hitMain),
    .selSram(selSram), .selRegs(selRegs), .selPio(selPio),
    .selSec(selSec), .selMain(selMain),
    .rdData(rdData), .cfgValue(cfgValue), .pioEn(pioEn)
  );

  // expected selects {sram, regs, pio, sec, main}
  function automatic logic [4:0] expSel(logic [7:0] c);
    logic code, dat;
    code = busFetch;
    dat  = !busFetch && (busRd || busWr);
    if (!code && !dat) return 5'b0;
    if (hitSram) return (dat || c[0]) ? 5'b10000 : 5'b0;
    if (hitRegs) return dat ? 5'b01000 : 5'b0;
    if (hitPio && c[7]) return dat ? 5'b00100 : 5'b0;
    if (hitSec) return ((code && c[2]) || (dat && c[4])) ? 5'b00010 : 5'b0;
    if (hitMain) return ((code && c[1]) || (dat && c[3])) ? 5'b00001 : 5'b0;
    return 5'b0;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check before posedge, advance model
  task automatic cycle(string req, logic f, logic r, logic w, logic [15:0] a,
                       logic [7:0] d, logic [4:0] hits, logic rs = 1'b1);
    logic [4:0] e;
    @(negedge clk);
    rstN = rs; busFetch = f; busRd = r; busWr = w; busAddr = a; busWdata = d;
    {hitSram, hitRegs, hitPio, hitSec, hitMain} = hits;
    #1;
    e = expSel(model);
    check({req, " R3 R8 selects"}, {3'b0, selSram, selRegs, selPio, selSec, selMain},
          {3'b0, e});
    check("R9 rdData", rdData,
          (e[3] && !f && r && !w && a == CADDR) ? model : IDLE);
    check("R2 cfgValue", cfgValue, model);
    @(posedge clk);
    if (!rs) model = CDEF & 8'h9F;
    else if (e[3] && !f && w && a == CADDR) model = d & 8'h9F;
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    cycle("R1", 0, 0, 0, 0, 0, 5'b0, 1'b0);
    cycle("R1", 0, 0, 0, 0, 0, 5'b0, 1'b0);
    check("R1 default", cfgValue, 8'h0C);
    // R5: default 0Ch, sec in code space, main in data space
    cycle("R5 sec fetch", 1, 0, 0, 16'h1000, 0, 5'b00010);
    check("R5 selSec", {7'b0, selSec}, 8'h1);
    cycle("R5 main data", 0, 1, 0, 16'h8000, 0, 5'b00001);
    check("R5 selMain", {7'b0, selMain}, 8'h1);
    cycle("R5 main fetch", 1, 0, 0, 16'h8000, 0, 5'b00001);
    check("R5 main no fetch", {7'b0, selMain}, 8'h0);
    // R4: SRAM fetch blocked under default, R3: no fall-through
    cycle("R4 R3 sram fetch", 1, 0, 0, 16'h2000, 0, 5'b10011);
    check("R4 R3 none", {3'b0, selSram, selRegs, selPio, selSec, selMain}, 8'h0);
    // R6: register block never on fetch
    cycle("R6", 1, 0, 0, CADDR, 0, 5'b01000);
    check("R6 regs fetch", {7'b0, selRegs}, 8'h0);
    // R10: fetch merged with write ignored
    cycle("R10", 1, 0, 1, CADDR, 8'hFF, 5'b01000);
    cycle("R10", 0, 0, 0, 0, 0, 5'b0);
    check("R10 unchanged", cfgValue, 8'h0C);
    // R2: write all ones, bits 6:5 dropped; then R9 read back
    cycle("R2", 0, 0, 1, CADDR, 8'hFF, 5'b01000);
    cycle("R9", 0, 1, 0, CADDR, 0, 5'b01000);
    check("R2 masked", cfgValue, 8'h9F);
    // R7: pio enabled now, data only
    cycle("R7 pio data", 0, 1, 0, 16'h4000, 0, 5'b00110);
    check("R7 selPio", {7'b0, selPio}, 8'h1);
    cycle("R7 pio fetch", 1, 0, 0, 16'h4000, 0, 5'b00110);
    // R7: bit 7 off, pio hit ignored, sec takes it
    cycle("R7", 0, 0, 1, CADDR, 8'h1F, 5'b01000);
    cycle("R7 pio off", 0, 1, 0, 16'h4000, 0, 5'b00110);
    check("R7 selSec", {6'b0, selPio, selSec}, 8'h1);
    // R1: reset restores default after a write
    cycle("R1", 0, 0, 0, 0, 0, 5'b0, 1'b0);
    cycle("R1", 0, 0, 0, 0, 0, 5'b0);
    check("R1 restore", cfgValue, 8'h0C);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] k;
      logic f, r, w, rs;
      logic [15:0] a;
      k = 3'($urandom_range(0, 5));
      f = (k == 1) || (k == 5);
      r = (k == 2);
      w = (k == 3) || (k == 5) || (k == 4);
      r = r || (k == 4);
      a = ($urandom_range(0, 3) != 0) ? CADDR : 16'($urandom);
      rs = ($urandom_range(0, 99) != 0);
      cycle("rand", f, r, w, a, 8'($urandom), 5'($urandom), rs);
    end
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule